// File: doc/BRIEF.md
# Switchable-Depth FIFO with Fill-Level Trigger

This block is a synchronous first-in first-out buffer for serial-port character traffic. It has a run-time mode switch. With the switch off, which is the state after reset, it keeps at most one entry and acts as a plain holding register. With the switch on, it uses its full depth of 16 entries. It reports empty and full, and it records a sticky overrun when a write arrives that it cannot take. The read port shows the oldest entry without a read latency. A pop request consumes that entry at the next clock edge.

A 3-bit level select chooses a fill threshold as a fraction of the full depth. From that threshold the block raises a level-sensitive trigger request for an interrupt controller. An elaboration parameter chooses the comparison direction. The receive variant requests service when enough entries have collected. The transmit variant requests service when the buffer has drained down to the threshold. The word width is also a parameter, so one design serves both an 8-bit transmit path and a 12-bit receive path that carries status bits with each character.

Top module: `fill_trigger_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `empty` is 1, `full` is 0, `overrun` is 0 and the mode is off (single entry).
- R2: With the mode off, one accepted push makes `full` 1, and the stored count never exceeds one.
- R3: With the mode on, the buffer accepts DEPTH (16) pushes before `full` becomes 1.
- R4: `rdata` always shows the oldest stored word, and words leave in the order they were pushed.
- R5: A push while `full` is 1 and no pop is requested is dropped and the contents stay unchanged. It also sets `overrun` to 1, and `overrun` stays 1 until reset.
- R6: A pop while `empty` is 1 is ignored and leaves the buffer empty.
- R7: In a cycle where `en` differs from the mode in force, the buffer is emptied at the next edge and that cycle's push and pop are ignored. From then on the new mode sets the capacity. `overrun` is not cleared.
- R8: `lvl_sel` codes 0, 1, 2, 3 and 4 give thresholds of DEPTH/8, DEPTH/4, DEPTH/2, 3·DEPTH/4 and 7·DEPTH/8 entries (2, 4, 8, 12 and 14 for a depth of 16). Codes 5, 6 and 7 act as code 2.
- R9: In the receive variant `trig` is 1 when the fill count is greater than or equal to the threshold. In the transmit variant `trig` is 1 when the fill count is less than or equal to the threshold. `trig` follows the current count and `lvl_sel` without delay.
- R10: A push and a pop in the same cycle are both taken when the buffer holds at least one entry, even when it is full, and the count stays the same. When the buffer is empty, only the push is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Mode switch: 1 uses the full depth, 0 holds one entry |
| push | input | 1 | Write request for `wdata` |
| pop | input | 1 | Request to remove the oldest entry |
| wdata | input | WIDTH | Word to be stored |
| lvl_sel | input | 3 | Trigger threshold select code |
| rdata | output | WIDTH | Oldest stored word |
| empty | output | 1 | No entries stored |
| full | output | 1 | Entry count equals the capacity of the current mode |
| overrun | output | 1 | Sticky flag: a push was dropped |
| trig | output | 1 | Fill-level service request |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One is the receive variant with 12-bit words. The other is the transmit variant with 8-bit words, so the two threshold comparisons and both word widths are covered in a single run. Both keep the default depth of 16, which puts every threshold code and the full boundary within reach of short random runs. Directed phases force mode flips next to pending pushes, drops while full, and simultaneous push and pop at both ends.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } trig_dir_e;

   function automatic int unsigned level_entries(input int unsigned depth,
                                                 input logic [2:0] code);
      int unsigned n;
      case (code)
         3'd0:    n = depth / 8;
         3'd1:    n = depth / 4;
         3'd3:    n = (depth * 3) / 4;
         3'd4:    n = (depth * 7) / 8;
         default: n = depth / 2;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/ftf_store.sv
module ftf_store #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ftf_ctrl.sv
module ftf_ctrl #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          push,
   input  logic          pop,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          overrun
);

   localparam logic [CW-1:0] CAP_ON  = CW'(DEPTH);
   localparam logic [CW-1:0] CAP_OFF = CW'(1);

   logic          mode_q;
   logic          flush;
   logic [CW-1:0] cap;
   logic          pop_ok;
   logic          push_ok;
   logic          drop;
   logic [AW-1:0] wptr_q;
   logic [AW-1:0] rptr_q;
   logic [CW-1:0] cnt_q;
   logic          ovr_q;

   assign flush   = (en != mode_q);
   assign cap     = mode_q ? CAP_ON : CAP_OFF;
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == cap);
   assign pop_ok  = pop & ~empty & ~flush;
   assign push_ok = push & ~flush & (~full | pop_ok);
   assign drop    = push & ~flush & ~push_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         mode_q <= en;
         if (drop) begin
            ovr_q <= 1'b1;
         end
         if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
         end else begin
            if (push_ok) begin
               wptr_q <= wptr_q + 1'b1;
            end
            if (pop_ok) begin
               rptr_q <= rptr_q + 1'b1;
            end
            case ({push_ok, pop_ok})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end

   assign wr_en   = push_ok;
   assign wr_addr = wptr_q;
   assign rd_addr = rptr_q;
   assign count   = cnt_q;
   assign overrun = ovr_q;

   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (empty && !full && !overrun && !mode_q));

   a_r2_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (cnt_q <= CW'(1)));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CAP_ON);

   a_r5_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (overrun && full && $stable(wptr_q)));

   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !flush) |=> (empty && $stable(rptr_q)));

   a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && (mode_q == $past(en))));

   a_r10_both_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop && !flush) |=> full);

endmodule

// File: rtl/ftf_trigger.sv
module ftf_trigger
   import ftf_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter trig_dir_e   DIR   = DIR_RX,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic [CW-1:0] count,
   input  logic [2:0]    lvl_sel,
   output logic          trig
);

   logic [CW-1:0] thr;

   always_comb begin
      thr = CW'(level_entries(DEPTH, lvl_sel));
   end

   generate
      if (DIR == DIR_RX) begin : g_rx
         assign trig = (count >= thr);
      end else begin : g_tx
         assign trig = (count <= thr);
      end
   endgenerate

   // R8: alias codes must land on the half threshold
   a_r8_alias: assert final ((lvl_sel < 3'd5) || (thr == CW'(DEPTH / 2)));

endmodule

// File: rtl/fill_trigger_fifo.sv
module fill_trigger_fifo
   import ftf_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16,
   parameter trig_dir_e   DIR   = DIR_RX,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   input  logic [2:0]       lvl_sel,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full,
   output logic             overrun,
   output logic             trig
);

   initial begin
      assert (WIDTH >= 1);
      assert (DEPTH >= 8);
      assert ((1 << AW) == DEPTH);
   end

   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_addr;
   logic [CW-1:0] count;

   ftf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .push    (push),
      .pop     (pop),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .count   (count),
      .empty   (empty),
      .full    (full),
      .overrun (overrun)
   );

   ftf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wdata),
      .rd_addr (rd_addr),
      .rd_data (rdata)
   );

   ftf_trigger #(.DEPTH(DEPTH), .DIR(DIR)) u_trig (
      .count   (count),
      .lvl_sel (lvl_sel),
      .trig    (trig)
   );

endmodule

// File: tb/fill_trigger_fifo_test.sv
module fill_trigger_fifo_test;
   import ftf_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, push = 1'b0, pop = 1'b0;
   logic [11:0] wdata = '0;
   logic [2:0]  lvl = 3'd2;
   logic [11:0] rd_rx;
   logic [7:0]  rd_tx;
   logic        emp_rx, ful_rx, ovr_rx, trg_rx;
   logic        emp_tx, ful_tx, ovr_tx, trg_tx;

   int nchk = 0, nerr = 0;

   logic        m_en;
   logic [2:0]  m_lvl;
   logic        m_ovr;
   logic [11:0] q[$];

   always #4 clk = ~clk;

   fill_trigger_fifo #(.WIDTH(12), .DEPTH(16), .DIR(DIR_RX)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .push(push), .pop(pop), .wdata(wdata),
      .lvl_sel(lvl), .rdata(rd_rx), .empty(emp_rx), .full(ful_rx),
      .overrun(ovr_rx), .trig(trg_rx));

   fill_trigger_fifo #(.WIDTH(8), .DEPTH(16), .DIR(DIR_TX)) uut_tx (
      .clk(clk), .rst_n(rst_n), .en(en), .push(push), .pop(pop), .wdata(wdata[7:0]),
      .lvl_sel(lvl), .rdata(rd_tx), .empty(emp_tx), .full(ful_tx),
      .overrun(ovr_tx), .trig(trg_tx));

   function automatic int thr(input logic [2:0] c);
      case (c)
         3'd0: return 2;
         3'd1: return 4;
         3'd3: return 12;
         3'd4: return 14;
         default: return 8;
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [11:0] act, input logic [11:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      int cap = m_en ? 16 : 1;
      int n   = q.size();
      string tf = m_en ? "R3" : "R2";
      chk("R6", "empty rx", 12'(emp_rx), 12'(n == 0));
      chk("R6", "empty tx", 12'(emp_tx), 12'(n == 0));
      chk(tf, "full rx", 12'(ful_rx), 12'(n == cap));
      chk(tf, "full tx", 12'(ful_tx), 12'(n == cap));
      chk("R5", "overrun rx", 12'(ovr_rx), 12'(m_ovr));
      chk("R5", "overrun tx", 12'(ovr_tx), 12'(m_ovr));
      if (n != 0) begin
         chk("R4", "rdata rx", rd_rx, q[0]);
         chk("R4", "rdata tx", 12'(rd_tx), 12'(q[0][7:0]));
      end
      chk("R8/R9", "trig rx", 12'(trg_rx), 12'(n >= thr(m_lvl)));
      chk("R8/R9", "trig tx", 12'(trg_tx), 12'(n <= thr(m_lvl)));
   endtask

   task automatic model_update(input logic e, p, o, input logic [11:0] d);
      int  cap = m_en ? 16 : 1;
      bit  emp = (q.size() == 0);
      bit  ful = (q.size() == cap);
      bit  dpop, dpush;
      if (e != m_en) begin
         q.delete();
         m_en = e;
      end else begin
         dpop  = o && !emp;
         dpush = p && (!ful || dpop);
         if (p && !dpush) m_ovr = 1'b1;
         if (dpop) void'(q.pop_front());
         if (dpush) q.push_back(d);
      end
   endtask

   task automatic step(input logic e, p, o, input logic [11:0] d, input logic [2:0] l);
      @(negedge clk);
      check_all();
      en = e; push = p; pop = o; wdata = d; lvl = l;
      @(posedge clk);
      model_update(e, p, o, d);
      m_lvl = l;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; en = 1'b0; push = 1'b0; pop = 1'b0; lvl = 3'd2;
      repeat (2) @(posedge clk);
      q.delete(); m_en = 1'b0; m_ovr = 1'b0; m_lvl = 3'd2;
      @(negedge clk);
      chk("R1", "reset empty", 12'(emp_rx & emp_tx), 12'd1);
      chk("R1", "reset full", 12'(ful_rx | ful_tx), 12'd0);
      chk("R1", "reset overrun", 12'(ovr_rx | ovr_tx), 12'd0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", "after release empty", 12'(emp_rx), 12'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      do_reset();

      // R2: holding register mode, second push dropped (R5)
      step(0, 1, 0, 12'hA51, 3'd2);
      step(0, 1, 0, 12'h0B2, 3'd2);
      step(0, 0, 0, 12'h0, 3'd2);
      chk("R2", "hold keeps first", rd_rx, 12'hA51);
      chk("R5", "overrun after drop", 12'(ovr_rx), 12'd1);
      // R10 at full in single mode
      step(0, 1, 1, 12'h3C4, 3'd0);
      step(0, 0, 0, 12'h0, 3'd0);
      chk("R10", "swap at full", rd_rx, 12'h3C4);

      // R7: mode flip with push pending is ignored and empties
      step(1, 1, 0, 12'h777, 3'd1);
      step(1, 0, 0, 12'h0, 3'd1);
      chk("R7", "flush empties", 12'(emp_rx), 12'd1);
      chk("R7", "overrun kept", 12'(ovr_rx), 12'd1);

      do_reset();
      step(1, 0, 0, 12'h0, 3'd2);
      // R3: fill 16 in full mode, walking thresholds (R8)
      for (int i = 0; i < 16; i++) step(1, 1, 0, 12'(i * 37 + 5), 3'(i % 8));
      step(1, 0, 0, 12'h0, 3'd4);
      chk("R3", "full at depth", 12'(ful_rx), 12'd1);
      chk("R5", "no overrun yet", 12'(ovr_rx), 12'd0);
      step(1, 1, 1, 12'hFEE, 3'd3);
      step(1, 1, 0, 12'h111, 3'd5);
      step(1, 0, 0, 12'h0, 3'd7);
      chk("R5", "overrun full mode", 12'(ovr_rx), 12'd1);
      for (int i = 0; i < 18; i++) step(1, 0, 1, 12'h0, 3'(i % 8));
      // R6: pops on empty, then R10 push+pop on empty
      step(1, 1, 1, 12'h5A5, 3'd0);
      step(1, 0, 0, 12'h0, 3'd0);
      chk("R10", "push taken on empty", rd_rx, 12'h5A5);

      for (int ph = 0; ph < 6; ph++) begin
         int pp = 20 + ph * 12;
         do_reset();
         for (int i = 0; i < 2500; i++) begin
            logic e = (($urandom % 300) == 0) ? ~m_en : ((ph == 0) ? m_en : 1'b1);
            if (i == 0) e = (ph != 0);
            step(e, ($urandom % 100) < pp + 10, ($urandom % 100) < 90 - pp,
                 12'($urandom), 3'($urandom));
         end
      end
      @(negedge clk);
      check_all();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule